// File: doc/BRIEF.md
# GPIO Interrupt Event Unit

This unit watches a bank of synchronised GPIO inputs and turns programmable pin events into one interrupt line for the bank. Each line has a 3-bit event code, supplied from outside. The code chooses one of five events: a low-to-high transition, a high-to-low transition, any transition, a low level or a high level. A detected event latches into a status word, whether or not the line is enabled.

Software enables lines by writing ones to an enable register and disables them by writing ones to a disable register. The resulting mask can be read back. The status word is read through the register port, and that same read clears it, so no acknowledge write is needed. The interrupt output is high while any latched event sits on an enabled line. Edges are found by comparing each input with its sample from the previous clock. The clock right after reset only captures that first sample.

Top module: `gpio_evt_unit`

## Requirements
- R1: After reset the mask and status words read as zero and `irq_o` is low.
- R2: A write to offset 0x20 sets every mask bit whose data bit is 1 and leaves the others unchanged; offset 0x28 reads back the mask.
- R3: A write to offset 0x24 clears every mask bit whose data bit is 1 and leaves the others unchanged.
- R4: Event code 0 latches a status bit when the line was 1 on the previous clock and is 0 now.
- R5: Event code 1 latches a status bit when the line was 0 on the previous clock and is 1 now.
- R6: Event code 2 latches a status bit on any change of the line between consecutive clocks.
- R7: Event code 3 latches a status bit on every clock the line is 0, so a line still low sets its bit again right after a status read.
- R8: Event code 4 latches a status bit on every clock the line is 1.
- R9: Event codes 5, 6 and 7 never latch a status bit.
- R10: A read at offset 0x2C returns the latched events and clears them; edge events are one-shot.
- R11: An event detected on the same clock as a status read is kept in the status word after the clear.
- R12: Status bits latch regardless of the mask and persist until read; `irq_o` is high exactly when status AND mask is non-zero.
- R13: No event is detected on the first clock after reset, even if a pin differs from its reset sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | NUM_LINES | Write data, one bit per line |
| bus_rdata | output | NUM_LINES | Read data for the current address, combinational |
| evt_sel | input | 3*NUM_LINES | Event code per line, line i in bits [3i+2:3i] |
| pin_in | input | NUM_LINES | Synchronised pin levels |
| irq_o | output | 1 | Bank interrupt |

## Verification
The hardest case to reach is an event that arrives on exactly the clock on which a status read clears the word. A second hard case is a level-selected line that stays active through a read. The directed phase reaches both by changing a pin while a status read is still on the bus, then reading again. Thousands of random cycles follow. In them, pins toggle sparsely, event codes change and reads and mask writes interleave. A bench-side model predicts every read and the interrupt level on each cycle.

// File: rtl/gpio_evt_pkg.sv
`timescale 1ns/1ps
package gpio_evt_pkg;
    localparam int SEL_W  = 3;
    localparam int REG_AW = 8;

    typedef enum logic [SEL_W-1:0] {
        EVT_FALL = 3'd0,
        EVT_RISE = 3'd1,
        EVT_BOTH = 3'd2,
        EVT_LOW  = 3'd3,
        EVT_HIGH = 3'd4
    } evt_kind_e;

    localparam logic [REG_AW-1:0] OFS_EN   = 8'h20;
    localparam logic [REG_AW-1:0] OFS_DIS  = 8'h24;
    localparam logic [REG_AW-1:0] OFS_MASK = 8'h28;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h2C;
endpackage

// File: rtl/gpio_evt_detect.sv
`timescale 1ns/1ps
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_LINES-1:0]       pin_i,
    input  logic [NUM_LINES*SEL_W-1:0] sel_i,
    output logic [NUM_LINES-1:0]       hit_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] prev;
        logic                 armed;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d       = det_q;
        det_d.prev  = pin_i;
        det_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) det_q <= '0;
        else     det_q <= det_d;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [SEL_W-1:0] code;
        logic             now_v;
        logic             was_v;
        logic             hit_g;

        assign code  = sel_i[g*SEL_W +: SEL_W];
        assign now_v = pin_i[g];
        assign was_v = det_q.prev[g];

        always_comb begin
            hit_g = 1'b0;
            if (det_q.armed) begin
                case (code)
                    EVT_FALL: hit_g = was_v & ~now_v;
                    EVT_RISE: hit_g = ~was_v & now_v;
                    EVT_BOTH: hit_g = was_v ^ now_v;
                    EVT_LOW:  hit_g = ~now_v;
                    EVT_HIGH: hit_g = now_v;
                    default:  hit_g = 1'b0;
                endcase
            end
        end

        assign hit_o[g] = hit_g;

        AST_UNUSED_CODE_QUIET: assert property (@(posedge clk) disable iff (rst)
            (code > 3'd4) |-> !hit_o[g]); // R9
        AST_RISE_SEEN: assert property (@(posedge clk) disable iff (rst)
            (det_q.armed && code == EVT_RISE && pin_i[g] && !$past(pin_i[g])) |-> hit_o[g]); // R5
    end
endmodule

// File: rtl/gpio_evt_regs.sv
`timescale 1ns/1ps
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_AW-1:0]     bus_addr,
    input  logic [NUM_LINES-1:0]  bus_wdata,
    input  logic [NUM_LINES-1:0]  hit_i,
    output logic [NUM_LINES-1:0]  rdata_o,
    output logic [NUM_LINES-1:0]  mask_o,
    output logic [NUM_LINES-1:0]  stat_o
);
    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] stat;
    } reg_t;

    reg_t reg_d, reg_q;
    logic wr_en, wr_dis, rd_stat;

    assign wr_en   = bus_sel &&  bus_wr && (bus_addr == OFS_EN);
    assign wr_dis  = bus_sel &&  bus_wr && (bus_addr == OFS_DIS);
    assign rd_stat = bus_sel && !bus_wr && (bus_addr == OFS_STAT);

    always_comb begin
        reg_d = reg_q;
        if (wr_en)  reg_d.mask = reg_q.mask | bus_wdata;
        if (wr_dis) reg_d.mask = reg_q.mask & ~bus_wdata;
        reg_d.stat = (rd_stat ? '0 : reg_q.stat) | hit_i;
    end

    always_ff @(posedge clk) begin
        if (rst) reg_q <= '0;
        else     reg_q <= reg_d;
    end

    always_comb begin
        case (bus_addr)
            OFS_MASK: rdata_o = reg_q.mask;
            OFS_STAT: rdata_o = reg_q.stat;
            default:  rdata_o = '0;
        endcase
    end

    assign mask_o = reg_q.mask;
    assign stat_o = reg_q.stat;

    AST_EN_SETS_MASK: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((reg_q.mask & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_DIS_CLEARS_MASK: assert property (@(posedge clk) disable iff (rst)
        wr_dis |=> ((reg_q.mask & $past(bus_wdata)) == '0)); // R3
    AST_READ_CLEARS_STATUS: assert property (@(posedge clk) disable iff (rst)
        rd_stat |=> (reg_q.stat == $past(hit_i))); // R10
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rd_stat |=> ((reg_q.stat & $past(reg_q.stat)) == $past(reg_q.stat))); // R12
endmodule

// File: rtl/gpio_evt_unit.sv
`timescale 1ns/1ps
module gpio_evt_unit
    import gpio_evt_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_sel,
    input  logic                       bus_wr,
    input  logic [REG_AW-1:0]          bus_addr,
    input  logic [NUM_LINES-1:0]       bus_wdata,
    output logic [NUM_LINES-1:0]       bus_rdata,
    input  logic [NUM_LINES*SEL_W-1:0] evt_sel,
    input  logic [NUM_LINES-1:0]       pin_in,
    output logic                       irq_o
);
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] stat;

    gpio_evt_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_in),
        .sel_i (evt_sel),
        .hit_o (hit)
    );

    gpio_evt_regs #(.NUM_LINES(NUM_LINES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit_i     (hit),
        .rdata_o   (bus_rdata),
        .mask_o    (mask),
        .stat_o    (stat)
    );

    assign irq_o = |(stat & mask);

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (mask != '0)); // R12
endmodule

// File: tb/gpio_evt_unit_tb.sv
`timescale 1ns/1ps
module gpio_evt_unit_tb;
    import gpio_evt_pkg::*;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [REG_AW-1:0] bus_addr = '0;
    logic [N-1:0]      bus_wdata = '0;
    logic [N-1:0]      bus_rdata;
    logic [N*SEL_W-1:0] evt_sel = {N{3'd7}};
    logic [N-1:0]      pin_in = '0;
    logic              irq_o;

    int n_tests = 0;
    int n_fail  = 0;

    gpio_evt_unit #(.NUM_LINES(N)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_sel(evt_sel), .pin_in(pin_in), .irq_o(irq_o)
    );

    // reference model built from the requirements
    logic [N-1:0] m_mask, m_stat, m_prev;
    logic         m_armed;

    function automatic logic [N-1:0] exp_hits(logic [N-1:0] p, logic [N-1:0] pv,
                                              logic [N*SEL_W-1:0] s, logic arm);
        logic [N-1:0] r;
        r = '0;
        for (int i = 0; i < N; i++) begin
            case (s[i*SEL_W +: SEL_W])
                3'd0:    r[i] = pv[i] & ~p[i];
                3'd1:    r[i] = ~pv[i] & p[i];
                3'd2:    r[i] = pv[i] ^ p[i];
                3'd3:    r[i] = ~p[i];
                3'd4:    r[i] = p[i];
                default: r[i] = 1'b0;
            endcase
        end
        return arm ? r : '0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask <= '0; m_stat <= '0; m_prev <= '0; m_armed <= 1'b0;
        end else begin
            m_stat <= ((bus_sel && !bus_wr && bus_addr == OFS_STAT) ? '0 : m_stat)
                      | exp_hits(pin_in, m_prev, evt_sel, m_armed);
            if (bus_sel && bus_wr && bus_addr == OFS_EN)  m_mask <= m_mask | bus_wdata;
            if (bus_sel && bus_wr && bus_addr == OFS_DIS) m_mask <= m_mask & ~bus_wdata;
            m_prev  <= pin_in;
            m_armed <= 1'b1;
        end
    end

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc_idle();
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0; #1;
    endtask

    task automatic cyc_write(input logic [REG_AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; #1;
    endtask

    task automatic cyc_read(input logic [REG_AW-1:0] a, output logic [N-1:0] d);
        @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic set_code(input int line, input logic [2:0] c);
        evt_sel[line*SEL_W +: SEL_W] = c;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [N-1:0] rd;
        void'($urandom(32'd2024));
        set_code(0, 3'd1);
        pin_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; #1;
        check("R1 irq after reset", {31'd0, irq_o}, '0);
        cyc_read(OFS_MASK, rd); check("R1 mask after reset", rd, '0);
        cyc_read(OFS_STAT, rd); check("R13 no event first clock", rd, '0);

        cyc_write(OFS_EN, 32'h0000_00F0);
        cyc_read(OFS_MASK, rd); check("R2 enable sets", rd, 32'h0000_00F0);
        cyc_write(OFS_EN, 32'h0000_0100);
        cyc_read(OFS_MASK, rd); check("R2 zeros keep", rd, 32'h0000_01F0);
        cyc_write(OFS_DIS, 32'h0000_0030);
        cyc_read(OFS_MASK, rd); check("R3 disable clears", rd, 32'h0000_01C0);
        cyc_write(OFS_DIS, 32'h0);
        cyc_read(OFS_MASK, rd); check("R3 zeros keep", rd, 32'h0000_01C0);

        // rising on line 6
        set_code(6, 3'd1); pin_in[6] = 1'b0;
        cyc_idle(); cyc_idle(); cyc_read(OFS_STAT, rd);
        pin_in[6] = 1'b1;
        cyc_read(OFS_STAT, rd); check("R5 rising", rd, 32'h40);
        check("R12 irq high", {31'd0, irq_o}, 32'h1);
        cyc_read(OFS_STAT, rd); check("R10 cleared one-shot", rd, '0);
        check("R12 irq low", {31'd0, irq_o}, '0);

        set_code(6, 3'd0); pin_in[6] = 1'b0;
        cyc_read(OFS_STAT, rd); check("R4 falling", rd, 32'h40);
        cyc_read(OFS_STAT, rd); check("R4 cleared", rd, '0);

        set_code(6, 3'd2); pin_in[6] = 1'b1;
        cyc_read(OFS_STAT, rd); check("R6 both rise", rd, 32'h40);
        cyc_read(OFS_STAT, rd); check("R6 cleared", rd, '0);
        pin_in[6] = 1'b0;
        cyc_read(OFS_STAT, rd); check("R6 both fall", rd, 32'h40);

        set_code(6, 3'd4);
        cyc_idle(); cyc_read(OFS_STAT, rd); check("R8 high idle low", rd, '0);
        pin_in[6] = 1'b1;
        cyc_read(OFS_STAT, rd); check("R8 high", rd, 32'h40);
        cyc_read(OFS_STAT, rd); check("R8 high persists", rd, 32'h40);
        pin_in[6] = 1'b0;
        cyc_read(OFS_STAT, rd); cyc_read(OFS_STAT, rd); check("R8 released", rd, '0);

        set_code(6, 3'd3);
        cyc_read(OFS_STAT, rd); check("R7 low", rd, 32'h40);
        cyc_read(OFS_STAT, rd); check("R7 re-set after read", rd, 32'h40);
        pin_in[6] = 1'b1;
        cyc_read(OFS_STAT, rd); cyc_read(OFS_STAT, rd); check("R7 released", rd, '0);

        set_code(2, 3'd1); pin_in[2] = 1'b1;
        cyc_read(OFS_STAT, rd); check("R12 latch while masked", rd, 32'h4);
        check("R12 irq masked", {31'd0, irq_o}, '0);

        for (int c = 5; c < 8; c++) begin
            set_code(6, 3'(c));
            pin_in[6] = ~pin_in[6]; cyc_idle();
            pin_in[6] = ~pin_in[6]; cyc_idle();
        end
        cyc_read(OFS_STAT, rd); check("R9 unused codes quiet", rd, '0);

        set_code(6, 3'd1); pin_in[6] = 1'b0;
        cyc_idle(); cyc_read(OFS_STAT, rd);
        cyc_read(OFS_STAT, rd);
        pin_in[6] = 1'b1;
        cyc_read(OFS_STAT, rd); check("R11 event during read kept", rd, 32'h40);

        for (int i = 0; i < N; i++) set_code(i, 3'($urandom % 8));
        for (int k = 0; k < 4000; k++) begin
            int op;
            if (($urandom % 16) == 0) set_code(int'($urandom % N), 3'($urandom % 8));
            pin_in = pin_in ^ ($urandom & $urandom & $urandom);
            op = int'($urandom % 10);
            case (op)
                0: cyc_write(OFS_EN, $urandom);
                1: cyc_write(OFS_DIS, $urandom & $urandom);
                2, 3, 4: begin
                    cyc_read(OFS_STAT, rd); check("R10 random status", rd, m_stat);
                end
                5: begin
                    cyc_read(OFS_MASK, rd); check("R2 random mask", rd, m_mask);
                end
                default: cyc_idle();
            endcase
            check("R12 random irq", {31'd0, irq_o}, {31'd0, |(m_stat & m_mask)});
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule